// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the management-port master for an Ethernet PHY. Software places a complete, pre-encoded 32-bit management frame into the data register with a single write. The word already carries the start pattern, opcode, PHY address, register address, turnaround pattern and data field. The controller then sends a run of preamble ones, followed by the frame word with the most significant bit first. The management clock comes from a programmable divider.

When the opcode is a read, the controller releases the data line for the turnaround and data bit times. It shifts the 16 bits returned by the PHY into the low half of the data register. When the last bit time ends, an event flag is set, and software clears it by writing a one to it. Transactions are accepted only while the management-enable control bit is set.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, every register reads as zero, and `mdc`, `mdio_oe`, `mdio_o` and `evt_done` are low. While no transaction is in progress, `mdc` stays low and `mdio_oe` stays low.
- R2: The register map is as follows. Address 0 is the frame/data word. Address 1 holds the done event in bit 0. Address 2 holds the clock divider in bits [DIV_W:1], and all other bits read as zero. Address 3 holds the enable bit in bit 0. `rdata` shows the register selected by `addr` at all times.
- R3: A write to address 0 while idle with enable set starts a transaction. The controller sends 32 bit times of MDIO = 1, then bits 31 down to 0 of the written word. `mdio_o` changes only on falling edges of `mdc`, and each bit is valid at the rising edge of `mdc`.
- R4: With divider value D > 0, each `mdc` high phase and each low phase lasts 2·D system clocks. The event is set 256·D clocks after the clock edge that accepted the write.
- R5: With a divider value of 0, `mdc` does not toggle and a transaction makes no progress. Once a nonzero value is written, the transaction continues and completes.
- R6: A frame whose bits [29:28] equal 10 is a read. `mdio_oe` is low for the last 18 bit times. On the last 16 rising edges of `mdc`, `mdio_i` is sampled MSB first into data bits [15:0], and bits [31:16] keep the written value.
- R7: For any other opcode value, for example 01 for a write, `mdio_oe` stays high for all 64 bit times and the data register keeps the written word.
- R8: The done event (address 1, bit 0, also on `evt_done`) is set when a transaction ends. Writing 1 to bit 0 clears it, and writing 0 leaves it set.
- R9: A write to address 0 during a transaction is ignored: the data register and the frame on the wire are unchanged.
- R10: A write to address 0 while the enable bit is clear stores the word but starts no transaction. No `mdc` edge occurs and no event is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register access select |
| we | input | 1 | Write strobe, qualified by cs |
| addr | input | 2 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for management data |
| mdio_i | input | 1 | Management data in |
| evt_done | output | 1 | Done event flag |

## Verification
A wrong bit counter or output index shows up at the `mdc` rising edges as a preamble count other than 32 or a misordered frame, within the same transaction. A divider or phase-counter fault changes the measured `mdc` high time and the write-to-event latency by whole multiples of 2·D clocks, which the bench detects on the first transaction. Errors in turnaround or capture show up after the first read, either as the count of driven bit times differing from 46 or as the low half of the data register differing from what the PHY model returned. Accept-guard faults show up as a lost or altered data word, or as spurious `mdc` edges, while the block is busy, disabled or has a divider of zero.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int DIV_W    = 6,
  parameter int PREAMBLE = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        evt_done
);
  localparam int TOTAL  = PREAMBLE + 32;
  localparam int BW     = $clog2(TOTAL);
  localparam int LAST   = TOTAL - 1;
  localparam int RD_TA  = TOTAL - 18;
  localparam int RD_CAP = TOTAL - 16;

  logic [31:0]      data_q;
  logic             evt_q, mode_q, busy_q, mdc_q, mdo_q, oe_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   cnt_q, half_m1;
  logic [BW-1:0]    bit_q, nb, fidx;
  logic             is_rd, tick, wr_data, start, nxt_mdo;

  assign is_rd   = data_q[29:28] == 2'b10;
  assign half_m1 = {div_q, 1'b0} - 1'b1;
  assign tick    = busy_q && (div_q != '0) && (cnt_q == half_m1);
  assign wr_data = cs && we && addr == 2'd0;
  assign start   = wr_data && !busy_q && mode_q;
  assign nb      = bit_q + 1'b1;
  assign fidx    = BW'(LAST) - nb;

  always_comb begin
    if (int'(nb) < PREAMBLE) nxt_mdo = 1'b1;
    else                     nxt_mdo = data_q[fidx[4:0]];
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = data_q;
      2'd1:    rdata = {31'd0, evt_q};
      2'd2:    rdata = 32'({div_q, 1'b0});
      default: rdata = {31'd0, mode_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; evt_q <= 1'b0; mode_q <= 1'b0; div_q <= '0;
      busy_q <= 1'b0; mdc_q <= 1'b0; mdo_q <= 1'b0; oe_q <= 1'b0;
      bit_q  <= '0; cnt_q <= '0;
    end else begin
      if (wr_data && !busy_q) data_q <= wdata;
      if (cs && we && addr == 2'd2) div_q <= wdata[DIV_W:1];
      if (cs && we && addr == 2'd3) mode_q <= wdata[0];

      if (tick && mdc_q && int'(bit_q) == LAST) evt_q <= 1'b1;
      else if (cs && we && addr == 2'd1 && wdata[0]) evt_q <= 1'b0;

      if (start) begin
        busy_q <= 1'b1; bit_q <= '0; cnt_q <= '0; mdc_q <= 1'b0;
        mdo_q  <= (PREAMBLE > 0) ? 1'b1 : wdata[31];
        oe_q   <= 1'b1;
      end else if (busy_q && div_q != '0) begin
        if (tick) begin
          cnt_q <= '0;
          mdc_q <= ~mdc_q;
          if (!mdc_q) begin
            if (is_rd && int'(bit_q) >= RD_CAP) data_q[15:0] <= {data_q[14:0], mdio_i};
          end else if (int'(bit_q) == LAST) begin
            busy_q <= 1'b0; oe_q <= 1'b0; mdo_q <= 1'b0;
          end else begin
            bit_q <= nb;
            mdo_q <= nxt_mdo;
            oe_q  <= !(is_rd && int'(nb) >= RD_TA);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mdc      = mdc_q;
  assign mdio_o   = mdo_q;
  assign mdio_oe  = oe_q;
  assign evt_done = evt_q;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic             we,
  input logic [1:0]       addr,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             evt_done,
  input logic             busy_q,
  input logic [31:0]      data_q,
  input logic [DIV_W-1:0] div_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q)) |-> (!mdc && !mdio_oe));

  // R3
  out_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc));

  // R5
  div_zero_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0 && $past(div_q == '0) && $past(busy_q) && busy_q) |-> $stable(mdc));

  // R8
  evt_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_done) |-> $fell(busy_q));

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cs && we && addr == 2'd0) |=> $stable(data_q[31:16]));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .evt_done(evt_done),
  .busy_q(busy_q), .data_q(data_q), .div_q(div_q)
);

// File: tb/mdio_frame_ctrl_test.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_test;
  logic clk = 0, rst = 1, cs = 0, we = 0, mdio_i;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic mdc, mdio_o, mdio_oe, evt_done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mdio_frame_ctrl uut (.clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .evt_done(evt_done));

  int rise_n = 0, ones = 0, oe_rises = 0;
  logic [31:0] frm = 0;
  logic [15:0] phy_val = 0;
  time t_rise = 0, hi_len = 0;

  assign mdio_i = (rise_n >= 48 && rise_n < 64) ? phy_val[63 - rise_n] : 1'b1;

  always @(posedge mdc) begin
    t_rise = $time;
    if (mdio_oe) begin
      oe_rises = oe_rises + 1;
      if (rise_n < 32) begin if (mdio_o) ones = ones + 1; end
      else frm = {frm[30:0], mdio_o};
    end
    rise_n = rise_n + 1;
  end
  always @(negedge mdc) hi_len = $time - t_rise;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #0.5; d = rdata;
  endtask

  task automatic mon_clear();
    rise_n = 0; ones = 0; oe_rises = 0; frm = 0; hi_len = 0;
  endtask

  task automatic run_txn(input logic [31:0] word, output int k);
    mon_clear();
    reg_wr(2'd0, word);
    k = 1;
    while (!evt_done && k < 5000) begin @(negedge clk); k++; end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, word;
    int k;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), r);
      chk(r == 0, "R1 reg reset", r, 0);
    end
    chk(!mdc && !mdio_oe && !mdio_o && !evt_done, "R1 pins reset", {mdc, mdio_oe, mdio_o, evt_done}, 0);

    reg_wr(2'd3, 1);
    reg_rd(2'd3, r); chk(r == 1, "R2 enable reg", r, 1);

    for (int d = 1; d <= 3; d++) begin
      for (int op = 0; op < 2; op++) begin
        int pa = (d * 7 + op * 11) % 32, ra = (d * 5 + op * 3 + 1) % 32;
        logic [15:0] dv = 16'hA5C3 ^ 16'(d * 16'h1357);
        reg_wr(2'd2, 32'(d << 1));
        reg_rd(2'd2, r); chk(r == 32'(d << 1), "R2 speed reg", r, d << 1);
        phy_val = 16'h3C5A ^ 16'(d * 16'h0F0F + op);
        word = (op ? 32'h60020000 : 32'h50020000) | (32'(pa) << 23) | (32'(ra) << 18) | (op ? 32'h0 : 32'(dv));
        run_txn(word, k);
        chk(k == 256 * d + 1, "R4 latency", k, 256 * d + 1);
        chk(hi_len == time'(8 * d), "R4 mdc high time", hi_len, 8 * d);
        chk(ones == 32, "R3 preamble", ones, 32);
        reg_rd(2'd0, r);
        if (op == 0) begin
          chk(oe_rises == 64, "R7 driven bits", oe_rises, 64);
          chk(frm == word, "R3 frame bits", frm, word);
          chk(r == word, "R7 data kept", r, word);
        end else begin
          chk(oe_rises == 46, "R6 driven bits", oe_rises, 46);
          chk(frm[13:0] == word[31:18], "R3 read header", frm[13:0], word[31:18]);
          chk(r == {word[31:16], phy_val}, "R6 captured", r, {word[31:16], phy_val});
        end
        chk(!mdio_oe && !mdc, "R1 idle after", {mdc, mdio_oe}, 0);
        reg_rd(2'd1, r); chk(r == 1, "R8 event set", r, 1);
        reg_wr(2'd1, 0);
        reg_rd(2'd1, r); chk(r == 1, "R8 write 0 keeps", r, 1);
        reg_wr(2'd1, 1);
        reg_rd(2'd1, r); chk(r == 0 && !evt_done, "R8 w1c", r, 0);
      end
    end

    reg_wr(2'd2, 2);
    word = 32'h5092BEEF;
    mon_clear();
    reg_wr(2'd0, word);
    repeat (40) @(negedge clk);
    reg_wr(2'd0, 32'h60AA1234);
    k = 0;
    while (!evt_done && k < 5000) begin @(negedge clk); k++; end
    reg_rd(2'd0, r); chk(r == word, "R9 busy write ignored", r, word);
    chk(frm == word, "R9 wire frame", frm, word);
    reg_wr(2'd1, 1);

    reg_wr(2'd3, 0);
    mon_clear();
    reg_wr(2'd0, 32'h50861111);
    repeat (600) @(negedge clk);
    chk(rise_n == 0 && !evt_done, "R10 no txn", rise_n, 0);
    reg_rd(2'd0, r); chk(r == 32'h50861111, "R10 stored", r, 32'h50861111);
    reg_wr(2'd3, 1);

    reg_wr(2'd2, 0);
    word = 32'h50C62222;
    mon_clear();
    reg_wr(2'd0, word);
    repeat (400) @(negedge clk);
    chk(rise_n == 0 && !mdc && !evt_done, "R5 frozen", rise_n, 0);
    reg_wr(2'd2, 2);
    k = 0;
    while (!evt_done && k < 5000) begin @(negedge clk); k++; end
    chk(evt_done == 1, "R5 resumes", evt_done, 1);
    chk(frm == word && ones == 32, "R5 frame after resume", frm, word);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule